// File: doc/BRIEF.md
# Capacitive Touch Pad Scanner

This block reads a row of capacitive touch pads. Each pad is an I/O pin with an external pull-up resistor and a capacitor to ground. The block repeats a fixed scan. It first drives every pad low so that the external capacitors fully discharge. It then releases all pads and lets the pull-ups recharge them.

A finger on a pad adds capacitance, so that pad crosses the input threshold later than a free pad. The block watches the synchronized pad levels. Once the first pad reads high, it waits one more clock and then takes one snapshot of all pads. Any pad that is still low in that snapshot counts as touched. Because detection is relative, a snapshot in which every pad is high means no touch, and touching every pad looks the same as touching none.

For each pad the block keeps a toggle bit. The bit flips on every new press, which is a transition from untouched to touched between two snapshots. If no pad rises within a timeout after release, the scan is abandoned and no state changes. Pad inputs pass through a two-flop synchronizer. The snapshot uses the synchronized levels, so the pipeline delay is the same for every pad.

Top module: `touch_scan`

## Requirements
- R1: While reset is asserted and right after it, `pad_oe` is all ones (every pad is driven low), and `touched`, `press_pulse` and `toggle_st` are all zero.
- R2: Each scan drives all pads low (`pad_oe` bit i = 1 drives pad i low) for exactly DISCH_CYC consecutive cycles, then releases all of them together. `pad_oe` is always either all ones or all zeros.
- R3: Consecutive scans start exactly PERIOD_CYC clock cycles apart.
- R4: One clock after the first synchronized pad reads high, all synchronized pad levels are sampled. Bit i of `touched` becomes 1 if pad i was still low at that point, and 0 otherwise.
- R5: A snapshot in which every pad reads high gives `touched` = 0 and no press pulse.
- R6: Up to three pads touched at the same time are each reported. Four pads touched with equal delay give `touched` = 0.
- R7: `press_pulse` bit i is high for one cycle when `touched` bit i goes from 0 to 1. A touch held across scans gives no further pulse. `toggle_st` bit i flips on each such pulse.
- R8: If no pad reads high within TIMEOUT_CYC cycles after release, the scan is abandoned. `touched` and `toggle_st` keep their values and no press pulse occurs.
- R9: Pads pass through two flip-flops before they are used. A pad whose raw input rises one clock after the first pad reads as untouched. A pad that rises two or more clocks later reads as touched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | N_PADS | Raw pad levels from the pins |
| pad_oe | output | N_PADS | 1 drives the pad low, 0 releases it to high impedance |
| touched | output | N_PADS | Touch vector from the latest completed snapshot |
| press_pulse | output | N_PADS | One-cycle pulse for each new press |
| toggle_st | output | N_PADS | Per-pad toggle state |

## Verification
The assertions take for granted that every pad reads low by the time it is released. This needs a discharge of at least two cycles, so that the synchronizer is flushed of stale highs. They also assume that a released pad rises monotonically and that PERIOD_CYC leaves room for the discharge, the timeout and the sample. The bench pad model holds each pad at 0 whenever its enable is set. After release, it raises each pad once at a per-pad delay counted from the release and keeps it high. Its parameters give ample margin between the scan phases.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic [1:0] {
    SEQ_DISCH  = 2'd0,
    SEQ_CHARGE = 2'd1,
    SEQ_SETTLE = 2'd2,
    SEQ_REST   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/tsc_sync.sv
module tsc_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1_q[i] <= 1'b0;
        stage2_q[i] <= 1'b0;
      end else begin
        stage1_q[i] <= d_in[i];
        stage2_q[i] <= stage1_q[i];
      end
    end
  end

  assign d_out = stage2_q;
endmodule

// File: rtl/tsc_seq.sv
module tsc_seq
  import tsc_pkg::*;
#(
  parameter int W           = 4,
  parameter int DISCH_CYC   = 16,
  parameter int PERIOD_CYC  = 3333,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_s,
  output logic         drive_low,
  output logic         sample_stb
);
  localparam int PH_MAX = (DISCH_CYC > TIMEOUT_CYC) ? DISCH_CYC : TIMEOUT_CYC;
  localparam int HW     = $clog2(PH_MAX + 1);
  localparam int PW     = $clog2(PERIOD_CYC + 1);

  seq_state_e    state_q, state_d;
  logic [HW-1:0] ph_cnt_q, ph_cnt_d;
  logic [PW-1:0] per_cnt_q, per_cnt_d;
  logic          any_high;

  assign any_high = |pad_s;

  always_comb begin
    state_d   = state_q;
    ph_cnt_d  = ph_cnt_q;
    per_cnt_d = (per_cnt_q == PW'(PERIOD_CYC)) ? per_cnt_q : per_cnt_q + 1'b1;
    unique case (state_q)
      SEQ_DISCH: begin
        if (ph_cnt_q == HW'(DISCH_CYC - 1)) begin
          state_d  = SEQ_CHARGE;
          ph_cnt_d = '0;
        end else begin
          ph_cnt_d = ph_cnt_q + 1'b1;
        end
      end
      SEQ_CHARGE: begin
        if (any_high) begin
          state_d = SEQ_SETTLE;
        end else if (ph_cnt_q == HW'(TIMEOUT_CYC - 1)) begin
          state_d = SEQ_REST;
        end else begin
          ph_cnt_d = ph_cnt_q + 1'b1;
        end
      end
      SEQ_SETTLE: begin
        state_d = SEQ_REST;
      end
      SEQ_REST: begin
        if (per_cnt_q >= PW'(PERIOD_CYC - 1)) begin
          state_d   = SEQ_DISCH;
          ph_cnt_d  = '0;
          per_cnt_d = '0;
        end
      end
      default: state_d = SEQ_DISCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SEQ_DISCH;
      ph_cnt_q  <= '0;
      per_cnt_q <= '0;
    end else begin
      state_q   <= state_d;
      ph_cnt_q  <= ph_cnt_d;
      per_cnt_q <= per_cnt_d;
    end
  end

  assign drive_low  = (state_q == SEQ_DISCH);
  assign sample_stb = (state_q == SEQ_SETTLE);

  // R8: the wait for a rising pad never outlasts the timeout window
  a_r8_charge_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_CHARGE) |-> (ph_cnt_q < HW'(TIMEOUT_CYC)));

  // R3: a new discharge begins only once the scan period has elapsed
  a_r3_period_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_low) |-> ($past(per_cnt_q) >= PW'(PERIOD_CYC - 1)));

  // R4: a snapshot is taken only right after a pad was seen high during charge
  a_r4_sample_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample_stb) |-> ($past(any_high) && $past(state_q) == SEQ_CHARGE));
endmodule

// File: rtl/tsc_eval.sv
module tsc_eval #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample_stb,
  input  logic [W-1:0] pad_s,
  output logic [W-1:0] touched,
  output logic [W-1:0] press,
  output logic [W-1:0] toggle
);
  logic [W-1:0] touched_q, touched_d;
  logic [W-1:0] press_q, press_d;
  logic [W-1:0] tog_q, tog_d;
  logic [W-1:0] low_now;

  assign low_now = ~pad_s;

  always_comb begin
    touched_d = touched_q;
    press_d   = '0;
    tog_d     = tog_q;
    if (sample_stb) begin
      touched_d = low_now;
      press_d   = low_now & ~touched_q;
      tog_d     = tog_q ^ press_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      touched_q <= '0;
      press_q   <= '0;
      tog_q     <= '0;
    end else begin
      touched_q <= touched_d;
      press_q   <= press_d;
      tog_q     <= tog_d;
    end
  end

  assign touched = touched_q;
  assign press   = press_q;
  assign toggle  = tog_q;

  // R7: a pulse never lasts two cycles on the same pad
  a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (|press_q) |=> ((press_q & $past(press_q)) == '0));

  // R7: toggle bits change exactly where a pulse appears
  a_r7_toggle_on_press: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 ((tog_q ^ $past(tog_q)) == press_q));

  // R7: a pulsing pad is reported as touched
  a_r7_press_in_touched: assert property (@(posedge clk) disable iff (!rst_n)
    ((press_q & ~touched_q) == '0));

  // R8: with no snapshot, no pulse and no change of touch state
  a_r8_no_sample_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |=> (press_q == '0 && $stable(touched_q)));

  // R5: an all-high snapshot reports no touch
  a_r5_allhigh_none: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && (&pad_s)) |=> (touched_q == '0 && press_q == '0));
endmodule

// File: rtl/touch_scan.sv
module touch_scan #(
  parameter int N_PADS      = 4,
  parameter int DISCH_CYC   = 16,
  parameter int PERIOD_CYC  = 3333,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PADS-1:0] pad_in,
  output logic [N_PADS-1:0] pad_oe,
  output logic [N_PADS-1:0] touched,
  output logic [N_PADS-1:0] press_pulse,
  output logic [N_PADS-1:0] toggle_st
);
  logic [N_PADS-1:0] pad_s;
  logic              drive_low;
  logic              sample_stb;

  tsc_sync #(.W(N_PADS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pad_in),
    .d_out (pad_s)
  );

  tsc_seq #(
    .W           (N_PADS),
    .DISCH_CYC   (DISCH_CYC),
    .PERIOD_CYC  (PERIOD_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .pad_s      (pad_s),
    .drive_low  (drive_low),
    .sample_stb (sample_stb)
  );

  tsc_eval #(.W(N_PADS)) u_eval (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_stb (sample_stb),
    .pad_s      (pad_s),
    .touched    (touched),
    .press      (press_pulse),
    .toggle     (toggle_st)
  );

  assign pad_oe = {N_PADS{drive_low}};

  // R1: the block comes out of reset discharging with clear outputs
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (pad_oe == '1 && touched == '0 && toggle_st == '0));
endmodule

// File: tb/touch_scan_tb_top.sv
module touch_scan_tb_top;
  localparam int NP  = 4;
  localparam int DC  = 8;
  localparam int PC  = 120;
  localparam int TC  = 40;
  localparam int FREE = 4;
  localparam int HELD = 7;

  logic          clk;
  logic          rst_n;
  logic [NP-1:0] pad_in;
  logic [NP-1:0] pad_oe;
  logic [NP-1:0] touched;
  logic [NP-1:0] press_pulse;
  logic [NP-1:0] toggle_st;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int rel   = 0;
  int dly [NP];
  int pcnt [NP];
  int cyc = 0;
  int last_rise = -1;
  int last_period = 0;
  int oe_run = 0;
  int last_disch = 0;
  int mix_err = 0;
  logic oe_prev = 1'b0;

  touch_scan #(
    .N_PADS(NP), .DISCH_CYC(DC), .PERIOD_CYC(PC), .TIMEOUT_CYC(TC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .pad_oe(pad_oe),
    .touched(touched), .press_pulse(press_pulse), .toggle_st(toggle_st)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // pad model and monitors, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (pad_oe[0]) rel = 0; else rel++;
    for (int i = 0; i < NP; i++) begin
      pad_in[i] = pad_oe[i] ? 1'b0 : (rel >= dly[i]);
      if (press_pulse[i]) pcnt[i]++;
    end
    if (rst_n) begin
      if (pad_oe != '0 && pad_oe != '1) mix_err++;
      if (pad_oe[0] && !oe_prev) begin
        if (last_rise >= 0) last_period = cyc - last_rise;
        last_rise = cyc;
        oe_run = 0;
      end
      if (pad_oe[0]) oe_run++;
      else if (oe_prev) last_disch = oe_run;
    end
    oe_prev = pad_oe[0];
  end

  always @(posedge clk) begin
    if (!done && cyc > 150000) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired: actual=%0d cycles expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_all(input int d);
    for (int i = 0; i < NP; i++) dly[i] = d;
  endtask

  // Runs one scan with the delays in dly and checks the outcome
  task automatic run_scan(input string req, input logic [NP-1:0] exp_t,
                          input logic [NP-1:0] exp_p, input logic [NP-1:0] exp_g);
    logic [NP-1:0] seen;
    for (int i = 0; i < NP; i++) pcnt[i] = 0;
    @(posedge pad_oe[0]);
    @(negedge clk);
    #1;
    seen = '0;
    for (int i = 0; i < NP; i++) begin
      if (pcnt[i] > 1) check({req, " pulse count"}, pcnt[i], 1);
      seen[i] = (pcnt[i] != 0);
    end
    check({req, " touched"}, touched, exp_t);
    check({req, " press"}, seen, exp_p);
    check({req, " toggle"}, toggle_st, exp_g);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    set_all(FREE);
    repeat (3) @(negedge clk);
    check("R1 oe in reset", pad_oe, 4'hF);
    check("R1 touched in reset", touched, 4'h0);
    check("R1 toggle in reset", toggle_st, 4'h0);
    check("R1 press in reset", press_pulse, 4'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 oe after release", pad_oe, 4'hF);
  endtask

  task automatic t_no_touch();
    set_all(FREE);
    run_scan("R5 none", 4'h0, 4'h0, 4'h0);
  endtask

  task automatic t_single_press();
    set_all(FREE); dly[0] = HELD;
    run_scan("R4 pad0 press", 4'h1, 4'h1, 4'h1);
    run_scan("R7 pad0 held", 4'h1, 4'h0, 4'h1);
  endtask

  task automatic t_one_late();
    set_all(FREE); dly[2] = FREE + 1;
    run_scan("R9 one clock late", 4'h0, 4'h0, 4'h1);
  endtask

  task automatic t_three();
    set_all(HELD); dly[0] = FREE;
    run_scan("R6 three pads", 4'hE, 4'hE, 4'hF);
  endtask

  task automatic t_timeout();
    set_all(100000);
    run_scan("R8 timeout", 4'hE, 4'h0, 4'hF);
  endtask

  task automatic t_all_four();
    set_all(HELD);
    run_scan("R6 all four", 4'h0, 4'h0, 4'hF);
  endtask

  task automatic t_retoggle();
    set_all(FREE); dly[0] = HELD;
    run_scan("R7 pad0 again", 4'h1, 4'h1, 4'hE);
  endtask

  task automatic t_timing();
    check("R2 discharge length", last_disch, DC);
    check("R3 scan period", last_period, PC);
    check("R2 enables uniform", mix_err, 0);
  endtask

  initial begin
    pad_in = '0;
    for (int i = 0; i < NP; i++) pcnt[i] = 0;
    t_reset();
    t_no_touch();
    t_single_press();
    t_one_late();
    t_three();
    t_timeout();
    t_all_four();
    t_retoggle();
    t_timing();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule